// File: doc/BRIEF.md
# Pseudo-Random Victim Way Selector

This block chooses which way of an 8-way set-associative cache receives the next fill. Two free-running sources generate candidate indices: a 3-bit counter that steps on every clock, and a 16-bit linear feedback shift register. A mode bit, set by privileged configuration logic outside the block, picks which source is used.

When the cache controller raises the miss strobe, the block samples the selected source on that clock edge. It presents the chosen way on a registered output in the next cycle, together with a one-cycle ready pulse. If any way of the addressed set is not valid, the block fills the lowest-numbered empty way and does not use the random index.

Both sources keep running whether a miss occurs or not and whichever mode is selected. A change of mode therefore applies from the next miss, and no restart is needed.

Top module: `way_victim_pick`

## Requirements
- R1: While `rst_ni` is low and after it rises, before any miss, `victim_o` is 0 and `victim_vld_o` is 0. The counter source starts at 0 and the LFSR starts at 16'hACE1.
- R2: The counter source adds 1 modulo 8 on every clock edge out of reset, regardless of `mode_i` and `miss_i`.
- R3: The LFSR shifts left by one bit on every clock edge out of reset. Bit 0 receives the XOR of state bits 15, 13, 12 and 10, which are taps 16, 14, 13 and 11. The state is never all zero.
- R4: With `mode_i`=0 and all 8 `valid_i` bits set, a miss selects the counter value held at the miss edge.
- R5: With `mode_i`=1 and all 8 `valid_i` bits set, a miss selects LFSR state bits [2:0] held at the miss edge.
- R6: If any `valid_i` bit is 0 at the miss edge, the victim is the index of the lowest 0 bit (bit i is way i), in either mode.
- R7: The victim appears on `victim_o` in the cycle after the miss edge, and `victim_vld_o` is high for that cycle only. With no miss, `victim_vld_o` is 0 and `victim_o` keeps its value.
- R8: A change of `mode_i` takes effect from the next miss, and the sequences of both sources continue unbroken.
- R9: A miss held high on consecutive edges produces a fresh victim and a ready pulse for each of those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Source select: 0 counter, 1 LFSR |
| miss_i | input | 1 | Miss strobe, one victim per high edge |
| valid_i | input | 8 | Valid bit of each way of the addressed set |
| victim_o | output | 3 | Registered victim way index |
| victim_vld_o | output | 1 | Victim ready pulse |

## Verification
The assertions check on every cycle that the counter steps by one, that the LFSR never becomes zero, and that every miss is followed by exactly one ready pulse. They also check that a set with an empty way always gets its lowest empty way, and that a full set gets the value of the selected source from the previous edge.

The exact LFSR sequence and its seed can be shown only by the bench's scenarios. The same holds for the absence of any restart when the mode changes, and for the hold of `victim_o` between misses. The bench sweeps all 256 valid patterns in both modes with varying idle gaps, and runs long full-set sequences in each mode.

// File: rtl/victim_pkg.sv
package victim_pkg;
  typedef enum logic {
    SRC_COUNT = 1'b0,
    SRC_LFSR  = 1'b1
  } src_e;

  localparam int unsigned LFSR_W_DEF = 16;
  // feedback taps 16,14,13,11 as bit mask on state[15:0]
  localparam logic [15:0] LFSR_TAPS_DEF = 16'hB400;
  localparam logic [15:0] LFSR_SEED_DEF = 16'hACE1;
endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/fib_lfsr.sv
module fib_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic fb;
  assign fb = ^(state_o & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= SEED;
    else         state_o <= {state_o[W-2:0], fb};
  end
endmodule

// File: rtl/empty_way_scan.sv
module empty_way_scan #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [WAYS-1:0]  valid_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan from the top so the lowest empty way wins
  always_comb begin
    idx_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = ~&valid_i;
endmodule

// File: rtl/way_victim_pick.sv
module way_victim_pick
  import victim_pkg::*;
#(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned LFSR_W = LFSR_W_DEF,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = LFSR_TAPS_DEF,
  parameter logic [LFSR_W-1:0] LFSR_SEED = LFSR_SEED_DEF,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             miss_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             victim_vld_o
);
  logic [IDX_W-1:0]  cnt_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic              empty_any;
  logic [IDX_W-1:0]  empty_idx;
  logic [IDX_W-1:0]  rand_idx;
  logic [IDX_W-1:0]  pick;
  src_e              src;

  step_counter #(.W(IDX_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q)
  );

  fib_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_q)
  );

  empty_way_scan #(.WAYS(WAYS), .IDX_W(IDX_W)) u_scan (
    .valid_i (valid_i),
    .any_o   (empty_any),
    .idx_o   (empty_idx)
  );

  assign src      = src_e'(mode_i);
  assign rand_idx = (src == SRC_LFSR) ? lfsr_q[IDX_W-1:0] : cnt_q;
  assign pick     = empty_any ? empty_idx : rand_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_o     <= '0;
      victim_vld_o <= 1'b0;
    end else begin
      victim_vld_o <= miss_i;
      if (miss_i) victim_o <= pick;
    end
  end
endmodule

// File: rtl/way_victim_pick_chk.sv
module way_victim_pick_chk #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned LFSR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              miss_i,
  input logic [WAYS-1:0]   valid_i,
  input logic [IDX_W-1:0]  victim_o,
  input logic              victim_vld_o,
  input logic [IDX_W-1:0]  cnt_i,
  input logic [LFSR_W-1:0] lfsr_i
);
  logic             armed_q;
  logic [WAYS-1:0]  valid_d;
  logic [WAYS-1:0]  low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      valid_d <= '1;
    end else begin
      armed_q <= 1'b1;
      valid_d <= valid_i;
    end
  end

  always_comb low_mask = (WAYS'(1) << victim_o) - WAYS'(1);

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_i == $past(cnt_i) + IDX_W'(1));

  p_lfsr_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_i != '0);

  p_cnt_pick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !mode_i && &valid_i) |=> victim_o == $past(cnt_i));

  p_lfsr_pick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && mode_i && &valid_i) |=> victim_o == $past(lfsr_i[IDX_W-1:0]));

  p_lowest_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !(&valid_i)) |=>
      (!valid_d[victim_o] && ((valid_d & low_mask) == low_mask)));

  p_vld_after_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> victim_vld_o);

  p_no_miss_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_i |=> (!victim_vld_o && $stable(victim_o)));
endmodule

bind way_victim_pick way_victim_pick_chk #(
  .WAYS(WAYS), .IDX_W(IDX_W), .LFSR_W(LFSR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .miss_i       (miss_i),
  .valid_i      (valid_i),
  .victim_o     (victim_o),
  .victim_vld_o (victim_vld_o),
  .cnt_i        (cnt_q),
  .lfsr_i       (lfsr_q)
);

// File: tb/sim_way_victim_pick.sv
module sim_way_victim_pick;
  localparam logic [15:0] SEED = 16'hACE1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic       miss_i = 1'b0;
  logic [7:0] valid_i = 8'hFF;
  logic [2:0] victim_o;
  logic       victim_vld_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of the sources, from R2/R3
  logic [2:0]  m_cnt  = 3'd0;
  logic [15:0] m_lfsr = SEED;
  logic [2:0]  exp_v  = 3'd0;

  way_victim_pick u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .miss_i       (miss_i),
    .valid_i      (valid_i),
    .victim_o     (victim_o),
    .victim_vld_o (victim_vld_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [2:0] low_zero(input logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (!v[i]) r = 3'(i);
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (miss_i) begin
        if (valid_i != 8'hFF) exp_v = low_zero(valid_i);
        else if (mode_i)      exp_v = m_lfsr[2:0];
        else                  exp_v = m_cnt;
      end
      m_cnt  = m_cnt + 3'd1;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic one_miss(input logic md, input logic [7:0] v, input int gap, input string req);
    logic [2:0] hold;
    repeat (gap) @(negedge clk_i);
    @(negedge clk_i);
    mode_i = md; valid_i = v; miss_i = 1'b1;
    @(negedge clk_i);
    miss_i = 1'b0;
    chk(victim_vld_o == 1'b1, "R7 ready", int'(victim_vld_o), 1);
    chk(victim_o == exp_v, req, int'(victim_o), int'(exp_v));
    hold = victim_o;
    valid_i = ~v;
    @(negedge clk_i);
    chk(victim_vld_o == 1'b0 && victim_o == hold, "R7 hold",
        int'({victim_vld_o, victim_o}), int'({1'b0, hold}));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(victim_o == 3'd0 && victim_vld_o == 1'b0, "R1 in reset",
        int'({victim_vld_o, victim_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(victim_o == 3'd0 && victim_vld_o == 1'b0, "R1 after reset",
        int'({victim_vld_o, victim_o}), 0);

    // R1/R2/R4: first miss in counter mode right after reset
    one_miss(1'b0, 8'hFF, 0, "R4 first count");
    // R1/R3/R5: lfsr from seed
    one_miss(1'b1, 8'hFF, 0, "R5 first lfsr");

    // R6: every valid pattern, both modes, varying gaps
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 256; v++)
        one_miss(1'(m), 8'(v), v % 5, (v == 255) ? (m ? "R5 sweep" : "R4 sweep") : "R6 sweep");

    // R2/R4: counter sequence with gaps
    for (int k = 0; k < 40; k++) one_miss(1'b0, 8'hFF, k % 7, "R2 R4 counter");
    // R3/R5: long lfsr run
    for (int k = 0; k < 120; k++) one_miss(1'b1, 8'hFF, k % 3, "R3 R5 lfsr");
    // R8: alternating modes, no restart
    for (int k = 0; k < 48; k++) one_miss(1'(k & 1), 8'hFF, k % 4, "R8 mode switch");

    // R9: miss held for three edges
    @(negedge clk_i);
    valid_i = 8'hFF; mode_i = 1'b0; miss_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      if (k == 1) mode_i = 1'b1;
      if (k == 2) miss_i = 1'b0;
      chk(victim_vld_o == 1'b1 && victim_o == exp_v, "R9 back-to-back",
          int'({victim_vld_o, victim_o}), int'({1'b1, exp_v}));
    end
    @(negedge clk_i);
    chk(victim_vld_o == 1'b0, "R7 pulse end", int'(victim_vld_o), 0);

    finish_run();
  end
endmodule